// File: doc/BRIEF.md
# Wide Immediate Move Unit

This execution unit loads a 16-bit immediate into a destination register at a chosen halfword position. It takes an already decoded request: the immediate, a halfword position, a two-bit opcode, a size bit that selects 32-bit or 64-bit operation, and a destination index. It computes the new register value and writes it into a small register file on the next rising clock edge.

There are three legal forms of the instruction. The first writes the bitwise complement of the positioned immediate. The second writes the positioned immediate with every other bit cleared. The third reads the current destination, replaces only the selected halfword with the immediate and writes the result back. Any encoding the unit does not support leaves every register unchanged and raises a registered illegal-instruction flag for one cycle. The unit has a second, independent read port so the surrounding logic can observe register contents.

Top module: `wmov_unit`

## Requirements
- R1: While reset is high and on the first cycle after it, every register reads zero and the illegal flag is low.
- R2: Opcode 2 writes the immediate shifted left by 16 times the halfword position, with all other bits zero.
- R3: Opcode 0 writes the bitwise complement of the shifted immediate.
- R4: Opcode 3 replaces bits [16*hw+15:16*hw] of the destination with the immediate and keeps every other bit of the old value.
- R5: Opcode 1 is reserved. It writes no register and raises the illegal flag in the cycle after the request.
- R6: With the size bit low (32-bit), a halfword position of 2 or 3 is illegal. It writes no register and raises the illegal flag in the cycle after the request.
- R7: With the size bit low, the result is truncated to its low 32 bits and bits 63:32 of the destination are written as zero. For opcode 3, only the low 32 bits of the old value take part in the merge.
- R8: Destination index 31 discards the write, and reading index 31 always returns zero.
- R9: When the valid strobe is low, no register changes and the illegal flag stays low in the next cycle.
- R10: The illegal flag is high for exactly one cycle per illegal request, and it is low after every legal request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe; the write happens on the next rising edge |
| req_wide | input | 1 | 1 selects 64-bit operation, 0 selects 32-bit operation |
| req_op | input | 2 | 0 = complement, 1 = reserved, 2 = zero-fill, 3 = halfword insert |
| req_hw | input | 2 | Halfword position; the shift is 16 times this value |
| req_imm | input | 16 | Immediate value |
| req_dst | input | 5 | Destination register index |
| rd_addr | input | 5 | Observation read port index |
| rd_data | output | 64 | Contents of register rd_addr |
| illegal_o | output | 1 | Registered illegal-instruction flag |

## Verification
The bench builds the unit with its default parameters: 64-bit registers, 16-bit immediates and 32 registers, where the top index is the discard register. With these values the four halfword positions cover the full register, the 32-bit mode has two legal and two illegal positions, and the discard index is 31. A chained table of requests applies the insert form to values that earlier complement and zero-fill writes left in place, so the keep behaviour is checked against non-trivial bit patterns in both sizes.

// File: rtl/wmov_pkg.sv
package wmov_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int DEF_XLEN  = 64;
    localparam int DEF_IMM_W = 16;
    localparam int DEF_NREGS = 32;

    // Opcode values are part of the instruction encoding
    typedef enum logic [1:0] {
        OP_INV  = 2'd0,
        OP_RSVD = 2'd1,
        OP_ZERO = 2'd2,
        OP_KEEP = 2'd3
    } wmov_op_e;

    typedef struct packed {
        logic     legal;
        logic     wr_en;
        wmov_op_e op;
    } wmov_ctl_t;

    // A position is legal when its lane lies inside the active width
    function automatic logic pos_ok(input logic wide, input int unsigned hw,
                                    input int unsigned narrow_lanes);
        return wide || (hw < narrow_lanes);
    endfunction
endpackage

// File: rtl/wmov_decode.sv
module wmov_decode
    import wmov_pkg::*;
#(
    parameter int LANES = 4,
    parameter int NREGS = 32,
    localparam int HW_W = $clog2(LANES),
    localparam int AW   = $clog2(NREGS),
    localparam int NARROW_LANES = LANES / 2
) (
    input  logic            valid,
    input  logic            wide,
    input  logic [1:0]      op_raw,
    input  logic [HW_W-1:0] hw,
    input  logic [AW-1:0]   dst,
    output wmov_ctl_t       ctl
);
    timeunit 1ns;
    timeprecision 1ps;

    wmov_op_e op;
    logic     op_ok;
    logic     hw_ok;
    logic     sink;

    always_comb begin
        op    = wmov_op_e'(op_raw);
        op_ok = (op != OP_RSVD);
        hw_ok = pos_ok(wide, int'(hw), NARROW_LANES);
        sink  = (dst == AW'(NREGS - 1));

        ctl.op    = op;
        ctl.legal = op_ok && hw_ok;
        ctl.wr_en = valid && op_ok && hw_ok && !sink;
    end
endmodule

// File: rtl/wmov_lanes.sv
module wmov_lanes
    import wmov_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int IMM_W = 16,
    localparam int LANES = XLEN / IMM_W,
    localparam int HW_W  = $clog2(LANES)
) (
    input  wmov_op_e         op,
    input  logic             wide,
    input  logic [HW_W-1:0]  hw,
    input  logic [IMM_W-1:0] imm,
    input  logic [XLEN-1:0]  cur,
    output logic [XLEN-1:0]  result
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [IMM_W-1:0] lane_val [LANES];

    // Each halfword lane decides its own value; only the addressed lane
    // receives the immediate, the others take the fill of the opcode.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam bit UPPER = (i >= LANES / 2);
        logic             hit;
        logic [IMM_W-1:0] old_bits;

        assign hit      = (hw == HW_W'(i));
        assign old_bits = cur[i*IMM_W +: IMM_W];

        always_comb begin
            unique case (op)
                OP_INV:  lane_val[i] = hit ? ~imm : '1;
                OP_ZERO: lane_val[i] = hit ? imm : '0;
                OP_KEEP: lane_val[i] = hit ? imm : old_bits;
                default: lane_val[i] = '0;
            endcase
            if (UPPER && !wide) begin
                lane_val[i] = '0;
            end
        end

        assign result[i*IMM_W +: IMM_W] = lane_val[i];
    end
endmodule

// File: rtl/wmov_regfile.sv
module wmov_regfile #(
    parameter int XLEN  = 64,
    parameter int NREGS = 32,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  logic [XLEN-1:0] wdata,
    input  logic [AW-1:0]   raddr_a,
    output logic [XLEN-1:0] rdata_a,
    input  logic [AW-1:0]   raddr_b,
    output logic [XLEN-1:0] rdata_b
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [XLEN-1:0] regs [NREGS];

    for (genvar r = 0; r < NREGS; r++) begin : g_reg
        if (r == NREGS - 1) begin : g_sink
            assign regs[r] = '0;
        end else begin : g_store
            always_ff @(posedge clk) begin
                if (rst) begin
                    regs[r] <= '0;
                end else if (we && (waddr == AW'(r))) begin
                    regs[r] <= wdata;
                end
            end
        end
    end

    assign rdata_a = regs[raddr_a];
    assign rdata_b = regs[raddr_b];
endmodule

// File: rtl/wmov_unit.sv
module wmov_unit
    import wmov_pkg::*;
#(
    parameter int XLEN  = DEF_XLEN,
    parameter int IMM_W = DEF_IMM_W,
    parameter int NREGS = DEF_NREGS,
    localparam int LANES = XLEN / IMM_W,
    localparam int HW_W  = $clog2(LANES),
    localparam int AW    = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_wide,
    input  logic [1:0]       req_op,
    input  logic [HW_W-1:0]  req_hw,
    input  logic [IMM_W-1:0] req_imm,
    input  logic [AW-1:0]    req_dst,
    input  logic [AW-1:0]    rd_addr,
    output logic [XLEN-1:0]  rd_data,
    output logic             illegal_o
);
    timeunit 1ns;
    timeprecision 1ps;

    wmov_ctl_t       ctl;
    logic [XLEN-1:0] dst_old;
    logic [XLEN-1:0] dst_new;
    logic            illegal_q;

    wmov_decode #(.LANES(LANES), .NREGS(NREGS)) i_decode (
        .valid  (req_valid),
        .wide   (req_wide),
        .op_raw (req_op),
        .hw     (req_hw),
        .dst    (req_dst),
        .ctl    (ctl)
    );

    wmov_lanes #(.XLEN(XLEN), .IMM_W(IMM_W)) i_lanes (
        .op     (ctl.op),
        .wide   (req_wide),
        .hw     (req_hw),
        .imm    (req_imm),
        .cur    (dst_old),
        .result (dst_new)
    );

    wmov_regfile #(.XLEN(XLEN), .NREGS(NREGS)) i_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (ctl.wr_en),
        .waddr   (req_dst),
        .wdata   (dst_new),
        .raddr_a (req_dst),
        .rdata_a (dst_old),
        .raddr_b (rd_addr),
        .rdata_b (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            illegal_q <= 1'b0;
        end else begin
            illegal_q <= req_valid && !ctl.legal;
        end
    end

    assign illegal_o = illegal_q;
endmodule

// File: rtl/wmov_unit_chk.sv
module wmov_unit_chk #(
    parameter int XLEN  = 64,
    parameter int HW_W  = 2,
    parameter int AW    = 5,
    parameter int NREGS = 32,
    localparam int NARROW_LANES = (1 << HW_W) / 2
) (
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic            req_wide,
    input logic [1:0]      req_op,
    input logic [HW_W-1:0] req_hw,
    input logic [AW-1:0]   rd_addr,
    input logic [XLEN-1:0] rd_data,
    input logic            illegal_o
);
    timeunit 1ns;
    timeprecision 1ps;

    logic narrow_bad;
    assign narrow_bad = !req_wide && (req_hw >= HW_W'(NARROW_LANES));

    // R5
    rsvd_op_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 2'd1) |=> illegal_o);

    // R6
    narrow_pos_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && narrow_bad) |=> illegal_o);

    // R9
    idle_no_flag_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !illegal_o);

    // R10
    legal_no_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op != 2'd1 && !narrow_bad) |=> !illegal_o);

    // R8
    sink_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == AW'(NREGS - 1)) |-> (rd_data == '0));
endmodule

bind wmov_unit wmov_unit_chk #(
    .XLEN(XLEN), .HW_W(HW_W), .AW(AW), .NREGS(NREGS)
) i_wmov_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_wide  (req_wide),
    .req_op    (req_op),
    .req_hw    (req_hw),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .illegal_o (illegal_o)
);

// File: tb/test_wmov_unit.sv
module test_wmov_unit;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_wide = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [1:0]  req_hw = 2'd0;
    logic [15:0] req_imm = 16'h0;
    logic [4:0]  req_dst = 5'd0;
    logic [4:0]  rd_addr = 5'd0;
    logic [63:0] rd_data;
    logic        illegal_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    wmov_unit i_wmov_unit (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_wide(req_wide),
        .req_op(req_op), .req_hw(req_hw), .req_imm(req_imm), .req_dst(req_dst),
        .rd_addr(rd_addr), .rd_data(rd_data), .illegal_o(illegal_o)
    );

    // {wide, op, hw, imm, dst, illegal, expected dst after}
    localparam int NV = 14;
    localparam logic [90:0] VEC [NV] = '{
        {1'b1, 2'd2, 2'd0, 16'h1234, 5'd1,  1'b0, 64'h0000_0000_0000_1234}, // R2
        {1'b1, 2'd2, 2'd3, 16'hABCD, 5'd2,  1'b0, 64'hABCD_0000_0000_0000}, // R2
        {1'b1, 2'd0, 2'd1, 16'h00FF, 5'd3,  1'b0, 64'hFFFF_FFFF_FF00_FFFF}, // R3
        {1'b1, 2'd3, 2'd2, 16'h5555, 5'd3,  1'b0, 64'hFFFF_5555_FF00_FFFF}, // R4
        {1'b1, 2'd3, 2'd0, 16'h0000, 5'd3,  1'b0, 64'hFFFF_5555_FF00_0000}, // R4
        {1'b1, 2'd1, 2'd0, 16'h7777, 5'd3,  1'b1, 64'hFFFF_5555_FF00_0000}, // R5
        {1'b0, 2'd2, 2'd1, 16'h8001, 5'd4,  1'b0, 64'h0000_0000_8001_0000}, // R7
        {1'b0, 2'd0, 2'd0, 16'h0001, 5'd5,  1'b0, 64'h0000_0000_FFFF_FFFE}, // R7
        {1'b0, 2'd3, 2'd0, 16'h1111, 5'd3,  1'b0, 64'h0000_0000_FF00_1111}, // R7
        {1'b0, 2'd2, 2'd2, 16'h1111, 5'd4,  1'b1, 64'h0000_0000_8001_0000}, // R6
        {1'b0, 2'd0, 2'd3, 16'h2222, 5'd5,  1'b1, 64'h0000_0000_FFFF_FFFE}, // R6
        {1'b1, 2'd0, 2'd0, 16'h0000, 5'd31, 1'b0, 64'h0000_0000_0000_0000}, // R8
        {1'b0, 2'd3, 2'd1, 16'hBEEF, 5'd4,  1'b0, 64'h0000_0000_BEEF_0000}, // R4
        {1'b1, 2'd3, 2'd3, 16'h1234, 5'd2,  1'b0, 64'h1234_0000_0000_0000}  // R4
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic read_reg(input logic [4:0] idx, output logic [63:0] val);
        rd_addr = idx;
        #0.5;
        val = rd_data;
    endtask

    // Drive one request at a falling edge; return one falling edge later
    task automatic issue(input logic wide, input logic [1:0] op, input logic [1:0] hw,
                         input logic [15:0] imm, input logic [4:0] dst, input logic vld);
        @(negedge clk);
        req_wide = wide; req_op = op; req_hw = hw; req_imm = imm;
        req_dst = dst; req_valid = vld;
        @(negedge clk);
        req_valid = 1'b0;
        rd_addr = dst;
        #0.5;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        logic [63:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #0.5;
        // R1: all registers zero and no flag after reset
        check("R1 flag after reset", {63'd0, illegal_o}, 64'd0);
        begin
            logic [63:0] acc;
            acc = '0;
            for (int r = 0; r < 32; r++) begin
                read_reg(5'(r), v);
                acc |= v;
            end
            check("R1 all registers zero", acc, 64'd0);
        end

        // Table walk
        for (int k = 0; k < NV; k++) begin
            logic [90:0] e;
            e = VEC[k];
            issue(e[90], e[89:88], e[87:86], e[85:70], e[69:65], 1'b1);
            check($sformatf("vector %0d value (R2..R8)", k), rd_data, e[63:0]);
            check($sformatf("vector %0d flag (R5/R6/R10)", k), {63'd0, illegal_o}, {63'd0, e[64]});
        end

        // R10: flag drops after an idle cycle following an illegal request
        issue(1'b1, 2'd1, 2'd2, 16'h4444, 5'd6, 1'b1);
        check("R5 reserved opcode flag", {63'd0, illegal_o}, 64'd1);
        check("R5 reserved opcode no write", rd_data, 64'd0);
        @(negedge clk); #0.5;
        check("R10 flag single cycle", {63'd0, illegal_o}, 64'd0);

        // R10: illegal then legal back to back
        @(negedge clk);
        req_wide = 1'b0; req_op = 2'd2; req_hw = 2'd3; req_imm = 16'h9999;
        req_dst = 5'd7; req_valid = 1'b1;
        @(negedge clk);
        req_wide = 1'b1; req_op = 2'd2; req_hw = 2'd1; req_imm = 16'h00AA;
        req_dst = 5'd7;
        #0.5;
        check("R6 flag before legal follow-up", {63'd0, illegal_o}, 64'd1);
        @(negedge clk);
        req_valid = 1'b0;
        rd_addr = 5'd7;
        #0.5;
        check("R10 flag low after legal request", {63'd0, illegal_o}, 64'd0);
        check("R2 follow-up write", rd_data, 64'h0000_0000_00AA_0000);

        // R9: strobe low, both legal and illegal encodings, nothing happens
        issue(1'b1, 2'd2, 2'd0, 16'hDEAD, 5'd8, 1'b0);
        check("R9 no write without strobe", rd_data, 64'd0);
        check("R9 no flag without strobe", {63'd0, illegal_o}, 64'd0);
        issue(1'b1, 2'd1, 2'd0, 16'hDEAD, 5'd8, 1'b0);
        check("R9 no flag for reserved without strobe", {63'd0, illegal_o}, 64'd0);

        // R8: index 31 read and discarded write
        read_reg(5'd31, v);
        check("R8 sink reads zero", v, 64'd0);

        // R1: reset during operation clears registers
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        read_reg(5'd3, v);
        check("R1 register cleared by reset", v, 64'd0);
        check("R1 flag low after reset", {63'd0, illegal_o}, 64'd0);

        done = 1'b1;
        finish_run();
    end
endmodule